// File: doc/BRIEF.md
# Infrared Pulse Codec

This block sits between a UART bit stream and an infrared transceiver. When the codec is switched on, every zero bit on the transmit side becomes one short light pulse. The width of that pulse is programmable. It is counted either on the base clock or on a 16x oversampling tick. One bits send no light at all. On the receive side, the codec turns each accepted light pulse back into a low UART-level bit that lasts for one bit time. The polarity of the transceiver output can be selected. An optional filter rejects pulses that are too short.

When the codec is switched off, both directions pass straight through and all internal state is cleared. The stream here is a single-bit line, not a word stream, so there is no valid/ready handshake and no back-pressure: every pin is a plain level or a one-cycle strobe sampled on `clk`. The block does not handle UART framing.

Top module: `irda_codec`

## Requirements
- R1: With `ir_en` low, `ir_tx` equals `tx_bit` and `rx_bit` equals `ir_rx` in the same cycle, and all pulse, filter and stretch state is cleared.
- R2: With `ir_en` high, a `tx_bit_start` strobe with `tx_bit` = 0 drives `ir_tx` high from the next cycle. `ir_tx` stays high for (`tx_plen`+1)*2 pulse-clock ticks.
- R3: With `ir_en` high, `ir_tx` idles low, and a `tx_bit_start` strobe with `tx_bit` = 1 starts no pulse.
- R4: The pulse clock is `os16_tick` only when `os16_en` = 1 and `pclk_sel` = 1. In every other case it is every `clk` cycle, so `pclk_sel` has no effect while `os16_en` = 0.
- R5: Light is seen when `ir_rx` differs from `rx_inv`. So `rx_inv` = 0 treats a high level as light, and `rx_inv` = 1 treats a low level as light.
- R6: With `rx_filt_en` = 0, a light pulse of a single cycle is accepted.
- R7: With `rx_filt_en` = 1, a light pulse shorter than (`rx_flen`+1)*2 cycles is ignored and leaves `rx_bit` high. A pulse of at least that length is accepted once.
- R8: An accepted pulse drives `rx_bit` low from the cycle after acceptance, for `bit_cycles` cycles (`bit_cycles` must be nonzero). A new acceptance during that time restarts the count.
- R9: After reset, with `ir_en` high and no light, `ir_tx` is 0 and `rx_bit` is 1.
- R10: A new zero-bit strobe while a pulse is still running restarts the full pulse width from that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_en | input | 1 | Codec enable; low means bypass |
| tx_bit | input | 1 | UART transmit level |
| tx_bit_start | input | 1 | One-cycle strobe at the start of each transmit bit |
| os16_en | input | 1 | Oversampling mode active |
| pclk_sel | input | 1 | Selects the 16x tick as pulse clock when oversampling |
| os16_tick | input | 1 | 16x bit-clock enable strobe |
| tx_plen | input | 6 | Transmit pulse length code |
| ir_tx | output | 1 | Infrared transmit line, high = light |
| ir_rx | input | 1 | Raw infrared receive line |
| rx_inv | input | 1 | Receive polarity: 1 = light is low |
| rx_filt_en | input | 1 | Receive filter enable |
| rx_flen | input | 6 | Receive minimum pulse length code |
| bit_cycles | input | 16 | Bit time in `clk` cycles |
| rx_bit | output | 1 | Decoded UART receive level |

## Verification
The bench targets the ends of the length codes (0 and 63). A design that drops the doubling, or that wraps its counter, would produce pulses of 1 or 0 cycles. Receive pulses exactly one cycle shorter than the filter threshold and exactly at it are tried; an off-by-one compare would accept the first or reject the second. The tests include a restart strobe in the middle of a pulse, `pclk_sel` set without oversampling (a design that obeys it would stretch the pulse), and both receive polarities (an inverted sense would decode the idle line as a stream of zeros).

// File: rtl/irda_codec_pkg.sv
package irda_codec_pkg;
  typedef enum logic {
    PCLK_BASE = 1'b0,
    PCLK_OS16 = 1'b1
  } pclk_src_e;

  localparam int unsigned LEN_W_DEF = 6;
  localparam int unsigned BITCNT_W_DEF = 16;
endpackage

// File: rtl/irda_tx_enc.sv
module irda_tx_enc #(
  parameter int unsigned PLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tx_bit,
  input  logic              bit_start,
  input  logic              tick,
  input  logic [PLEN_W-1:0] plen,
  output logic              pulse
);
  localparam int unsigned CW = PLEN_W + 2;

  logic [CW-1:0] rem_q;
  logic [CW-1:0] width;
  logic          zero_start;

  // (plen + 1) * 2 pulse-clock ticks
  assign width      = (CW'(plen) + CW'(1)) << 1;
  assign zero_start = bit_start & ~tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (!en) begin
      rem_q <= '0;
    end else if (zero_start) begin
      rem_q <= width;
    end else if (rem_q != '0 && tick) begin
      rem_q <= rem_q - CW'(1);
    end
  end

  assign pulse = (rem_q != '0);
endmodule

// File: rtl/irda_rx_filt.sv
module irda_rx_filt #(
  parameter int unsigned FLEN_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              light,
  input  logic              filt_en,
  input  logic [FLEN_W-1:0] flen,
  output logic              accept
);
  localparam int unsigned RW = FLEN_W + 2;
  localparam logic [RW-1:0] RUN_MAX = '1;

  logic [RW-1:0] run_q;
  logic [RW-1:0] need;

  assign need   = filt_en ? ((RW'(flen) + RW'(1)) << 1) : RW'(1);
  assign accept = en & light & (run_q == need - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en || !light) begin
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + RW'(1);
    end
  end
endmodule

// File: rtl/irda_rx_stretch.sv
module irda_rx_stretch #(
  parameter int unsigned BITCNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                accept,
  input  logic [BITCNT_W-1:0] bit_cycles,
  output logic                low_active
);
  logic [BITCNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (!en) begin
      left_q <= '0;
    end else if (accept) begin
      left_q <= bit_cycles;
    end else if (left_q != '0) begin
      left_q <= left_q - BITCNT_W'(1);
    end
  end

  assign low_active = (left_q != '0);
endmodule

// File: rtl/irda_codec.sv
module irda_codec
  import irda_codec_pkg::*;
#(
  parameter int unsigned LEN_W    = LEN_W_DEF,
  parameter int unsigned BITCNT_W = BITCNT_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ir_en,
  input  logic                tx_bit,
  input  logic                tx_bit_start,
  input  logic                os16_en,
  input  logic                pclk_sel,
  input  logic                os16_tick,
  input  logic [LEN_W-1:0]    tx_plen,
  output logic                ir_tx,
  input  logic                ir_rx,
  input  logic                rx_inv,
  input  logic                rx_filt_en,
  input  logic [LEN_W-1:0]    rx_flen,
  input  logic [BITCNT_W-1:0] bit_cycles,
  output logic                rx_bit
);
  pclk_src_e src;
  logic      ptick;
  logic      pulse;
  logic      light;
  logic      accept;
  logic      low_active;

  assign src   = (os16_en && pclk_sel) ? PCLK_OS16 : PCLK_BASE;
  assign ptick = (src == PCLK_OS16) ? os16_tick : 1'b1;
  assign light = ir_rx ^ rx_inv;

  irda_tx_enc #(.PLEN_W(LEN_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(ir_en), .tx_bit(tx_bit),
    .bit_start(tx_bit_start), .tick(ptick), .plen(tx_plen), .pulse(pulse)
  );

  irda_rx_filt #(.FLEN_W(LEN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(ir_en), .light(light),
    .filt_en(rx_filt_en), .flen(rx_flen), .accept(accept)
  );

  irda_rx_stretch #(.BITCNT_W(BITCNT_W)) u_str (
    .clk(clk), .rst_n(rst_n), .en(ir_en), .accept(accept),
    .bit_cycles(bit_cycles), .low_active(low_active)
  );

  assign ir_tx  = ir_en ? pulse : tx_bit;
  assign rx_bit = ir_en ? ~low_active : ir_rx;
endmodule

// File: rtl/irda_codec_chk.sv
module irda_codec_chk #(
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned BITCNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ir_en,
  input logic             tx_bit,
  input logic             tx_bit_start,
  input logic             ir_tx,
  input logic             ir_rx,
  input logic             rx_inv,
  input logic             rx_filt_en,
  input logic [LEN_W-1:0] rx_flen,
  input logic             rx_bit
);
  logic [LEN_W+1:0] chk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= '0;
    else if (ir_en && (ir_rx ^ rx_inv)) begin
      if (chk_run != '1) chk_run <= chk_run + 1'b1;
    end else chk_run <= '0;
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_en |-> (ir_tx == tx_bit && rx_bit == ir_rx));

  p_zero_starts_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && tx_bit_start && !tx_bit) |=> (ir_tx || !ir_en));

  p_quiet_stays_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && !ir_tx && !(tx_bit_start && !tx_bit)) |=> (!ir_tx || !ir_en));

  p_fall_needs_light_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $fell(rx_bit)) |-> $past(ir_rx ^ rx_inv));

  p_filter_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_en && $past(ir_en) && $past(rx_filt_en) && $fell(rx_bit))
      |-> (chk_run >= (({2'b00, $past(rx_flen)} + 1'b1) << 1)));
endmodule

bind irda_codec irda_codec_chk #(.LEN_W(LEN_W), .BITCNT_W(BITCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .tx_bit(tx_bit),
  .tx_bit_start(tx_bit_start), .ir_tx(ir_tx), .ir_rx(ir_rx),
  .rx_inv(rx_inv), .rx_filt_en(rx_filt_en), .rx_flen(rx_flen),
  .rx_bit(rx_bit)
);

// File: tb/irda_codec_tb_top.sv
module irda_codec_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic ir_en = 0, tx_bit = 1, tx_bit_start = 0;
  logic os16_en = 0, pclk_sel = 0, os16_tick = 0;
  logic [5:0] tx_plen = 0, rx_flen = 0;
  logic ir_rx = 0, rx_inv = 0, rx_filt_en = 0;
  logic [15:0] bit_cycles = 16'd20;
  logic ir_tx, rx_bit;

  int checks = 0, fails = 0, tick_ctr = 0;
  bit os16_run = 0;
  string cur_req = "R9";

  // behavioural reference state
  int m_tx_rem = 0, m_rx_run = 0, m_rx_low = 0;

  always #(CLK_P/2) clk = ~clk;

  irda_codec dut_i (
    .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .tx_bit(tx_bit),
    .tx_bit_start(tx_bit_start), .os16_en(os16_en), .pclk_sel(pclk_sel),
    .os16_tick(os16_tick), .tx_plen(tx_plen), .ir_tx(ir_tx), .ir_rx(ir_rx),
    .rx_inv(rx_inv), .rx_filt_en(rx_filt_en), .rx_flen(rx_flen),
    .bit_cycles(bit_cycles), .rx_bit(rx_bit)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !ir_en) begin
      m_tx_rem = 0; m_rx_run = 0; m_rx_low = 0;
    end else begin
      int need;
      bit tick, lit, acc;
      tick = (os16_en && pclk_sel) ? os16_tick : 1'b1;
      if (tx_bit_start && !tx_bit) m_tx_rem = (int'(tx_plen) + 1) * 2;
      else if (m_tx_rem > 0 && tick) m_tx_rem--;
      lit  = ir_rx ^ rx_inv;
      need = rx_filt_en ? (int'(rx_flen) + 1) * 2 : 1;
      acc  = lit && (m_rx_run == need - 1);
      m_rx_run = lit ? ((m_rx_run < 255) ? m_rx_run + 1 : 255) : 0;
      if (acc) m_rx_low = int'(bit_cycles);
      else if (m_rx_low > 0) m_rx_low--;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the edge
  always @(negedge clk) if (rst_n) begin
    bit ex_tx, ex_rx;
    ex_tx = ir_en ? (m_tx_rem != 0) : tx_bit;
    ex_rx = ir_en ? (m_rx_low == 0) : ir_rx;
    check(ir_tx == ex_tx, {cur_req, " ir_tx"}, int'(ir_tx), int'(ex_tx));
    check(rx_bit == ex_rx, {cur_req, " rx_bit"}, int'(rx_bit), int'(ex_rx));
  end

  task automatic step();
    @(posedge clk); #(CLK_P/4);
    tick_ctr++;
    os16_tick = os16_run && (tick_ctr % 4 == 0);
  endtask

  task automatic send_bit(bit b, output int w);
    tx_bit = b; tx_bit_start = 1; step();
    tx_bit_start = 0; tx_bit = 1; w = 0;
    for (int i = 0; i < 700; i++) begin
      if (ir_tx) w++; else if (w > 0) break;
      step();
    end
  endtask

  task automatic rx_pulse(int len, output int w);
    w = 0;
    ir_rx = ~rx_inv;
    for (int i = 0; i < len; i++) begin step(); if (!rx_bit) w++; end
    ir_rx = rx_inv;
    for (int i = 0; i < 100; i++) begin step(); if (!rx_bit) w++; end
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w, w2;
    ir_en = 1;
    repeat (3) step();
    rst_n = 1; step();
    cur_req = "R9";
    check(ir_tx == 0, "R9 reset ir_tx", ir_tx, 0);
    check(rx_bit == 1, "R9 reset rx_bit", rx_bit, 1);

    // R1 bypass
    cur_req = "R1"; ir_en = 0;
    tx_bit = 0; ir_rx = 0; step();
    check(ir_tx == 0 && rx_bit == 0, "R1 bypass low", ir_tx, 0);
    tx_bit = 1; ir_rx = 1; step();
    check(ir_tx == 1 && rx_bit == 1, "R1 bypass high", rx_bit, 1);
    ir_rx = 0; ir_en = 1; step();

    // R2 widths at code ends
    cur_req = "R2";
    tx_plen = 3;  send_bit(0, w); check(w == 8, "R2 plen=3", w, 8);
    tx_plen = 0;  send_bit(0, w); check(w == 2, "R2 plen=0", w, 2);
    tx_plen = 63; send_bit(0, w); check(w == 128, "R2 plen=63", w, 128);

    // R3 one bit gives no pulse
    cur_req = "R3"; tx_plen = 3;
    send_bit(1, w); check(w == 0, "R3 one bit", w, 0);

    // R4 pulse clock selection
    cur_req = "R4";
    os16_en = 0; pclk_sel = 1; send_bit(0, w);
    check(w == 8, "R4 sel ignored w/o os16", w, 8);
    os16_run = 1; os16_en = 1; tx_plen = 1; send_bit(0, w);
    check(w >= 13 && w <= 16, "R4 os16 tick width", w, 16);
    os16_run = 0; os16_en = 0; pclk_sel = 0; os16_tick = 0;

    // R10 restart during pulse
    cur_req = "R10"; tx_plen = 3;
    tx_bit = 0; tx_bit_start = 1; step(); tx_bit_start = 0; tx_bit = 1;
    step(); step();
    tx_bit = 0; tx_bit_start = 1; step(); tx_bit_start = 0; tx_bit = 1;
    w = 3;
    for (int i = 0; i < 50; i++) begin if (ir_tx) w++; else break; step(); end
    check(w == 11, "R10 restart width", w, 11);

    // R6 / R8 no filter, single cycle
    cur_req = "R6"; rx_inv = 0; ir_rx = 0; bit_cycles = 20; step();
    rx_pulse(1, w); check(w == 20, "R6 R8 1-cycle accepted", w, 20);
    cur_req = "R8"; bit_cycles = 7;
    rx_pulse(3, w); check(w == 7, "R8 bit time low", w, 7);

    // R5 inverted polarity
    cur_req = "R5"; rx_inv = 1; ir_rx = 1;
    for (int i = 0; i < 10; i++) step();
    check(rx_bit == 1, "R5 idle inverted", rx_bit, 1);
    rx_pulse(2, w); check(w == 7, "R5 low pulse accepted", w, 7);
    rx_inv = 0; ir_rx = 0; step();

    // R7 filter threshold
    cur_req = "R7"; rx_filt_en = 1; rx_flen = 2; bit_cycles = 10;
    rx_pulse(5, w);  check(w == 0, "R7 short ignored", w, 0);
    rx_pulse(6, w2); check(w2 == 10, "R7 threshold accepted", w2, 10);
    rx_pulse(40, w); check(w == 10, "R7 long accepted once", w, 10);

    repeat (5) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule